// File: doc/BRIEF.md
# DLL Bring-up and Relock Sequencer

This controller-side block brings a DDR SRAM with an on-die delay-locked loop out of power-up and keeps the loop valid while the system runs. The DLL-enable pin is held low until the supply reports good and the forwarded clock reports stable. The pin is then released. A lock wait of a fixed number of cycles follows, and only then may the memory controller issue commands.

The block also tracks an unbroken run of non-read cycles after power-up, which the output driver needs to settle its impedance. Readiness is withheld until both the lock wait and that run are complete.

When the operating frequency is about to change, when the clock goes unstable, or when software puts the memory into a low-power clock-stop, the sequencer gates the forwarded clock off. The stop lasts at least the time needed to reset the DLL, rounded up to whole reference cycles. The clock is then restarted and a full lock wait follows. A frequency request whose period is too long for the DLL is refused and flagged.

Top module: `dll_bringup_seq`

## Requirements
- R1: Out of reset, and for as long as `pwr_good` is low or `clk_stable` has not yet been seen high with power good, `dll_run`, `clk_gate_en` and `ready` are all low.
- R2: With `pwr_good` high, `clk_gate_en` turns on one cycle after power is seen good. `dll_run` turns on at the first clock edge that samples `clk_stable` high after that.
- R3: After the sequencer enters its lock-wait state, `ready` rises no earlier than LOCK_CYCLES (default 1024) clock edges later. It rises exactly then when the impedance run is already complete.
- R4: `ready` also waits for ZQ_CYCLES (default 1024) consecutive cycles with the clock on and `rd_cmd` low, counted since power became good. A read during the run restarts it from zero, and `ready` rises ZQ_CYCLES+1 edges after the edge that sampled the read. Once complete, the run is kept until power is lost.
- R5: A `freq_req` whose `req_period_ps` is at most MAX_PERIOD_PS (8400) drops `ready` in the same cycle and turns `clk_gate_en` off for exactly STOP_CYC cycles. STOP_CYC = ceil(STOP_NS*1000 / REF_PERIOD_PS), which is 6 by default. A full lock wait then follows. A period of exactly 8400 is accepted.
- R6: A `freq_req` with `req_period_ps` above MAX_PERIOD_PS sets `period_err` on the next edge and has no effect on `ready`, `dll_run` or `clk_gate_en`. The next accepted request clears `period_err`.
- R7: While `sleep_req` is high, `ready` is low and the clock gate is off, with `dll_run` kept high. After release, the clock restarts once at least STOP_CYC stopped cycles have passed, and a full lock wait follows.
- R8: Losing `clk_stable` while the DLL is enabled drops `ready` in the same cycle and gates the clock off while `dll_run` stays high. The clock restarts after `clk_stable` returns, and the stop lasts at least STOP_CYC cycles even if the clock is unstable for a shorter time. A full lock wait follows.
- R9: Losing `pwr_good` drops `ready` at once. On the next edge it also drops `dll_run` and `clk_gate_en`, and it clears the impedance run, so the whole power-up sequence repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supplies reported stable |
| clk_stable | input | 1 | Memory clocks reported stable |
| freq_req | input | 1 | One-cycle request to change the operating frequency |
| req_period_ps | input | PERIOD_W | Requested clock period in picoseconds, valid with `freq_req` |
| sleep_req | input | 1 | Hold the memory in clock-stop low-power state |
| rd_cmd | input | 1 | A read command is issued this cycle |
| dll_run | output | 1 | DLL-enable pin level; low keeps the DLL disabled |
| clk_gate_en | output | 1 | Enables the clock forwarded to the memory |
| ready | output | 1 | Commands may be issued |
| period_err | output | 1 | Last frequency request asked for a period the DLL cannot lock to |

## Verification
The hardest case to reach is `ready` being held back by the impedance run rather than by the lock count. In normal bring-up the run starts several cycles before the lock wait and always finishes first. To reach this case, the stimulus drops power so the run is cleared, then restores it. It then issues a single read late in the lock window, so the run restarts and ends after the lock count. The expected rise edge is taken as the later of the two bounds. The short clock-instability case is also driven on purpose: `clk_stable` drops for only two cycles, which shows that the stop still lasts the full DLL-reset window.

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq #(
  parameter int REF_PERIOD_PS = 5000,
  parameter int STOP_NS       = 30,
  parameter int LOCK_CYCLES   = 1024,
  parameter int ZQ_CYCLES     = 1024,
  parameter int MAX_PERIOD_PS = 8400,
  parameter int PERIOD_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_good,
  input  logic                clk_stable,
  input  logic                freq_req,
  input  logic [PERIOD_W-1:0] req_period_ps,
  input  logic                sleep_req,
  input  logic                rd_cmd,
  output logic                dll_run,
  output logic                clk_gate_en,
  output logic                ready,
  output logic                period_err
);
  localparam int STOP_CYC = (STOP_NS * 1000 + REF_PERIOD_PS - 1) / REF_PERIOD_PS;
  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam int ZCW = $clog2(ZQ_CYCLES + 1);
  localparam int SCW = $clog2(STOP_CYC + 1);

  typedef enum logic [2:0] {
    WAIT_POWER, WAIT_CLK, ENABLE, LOCK_COUNT, READY, CLK_STOP
  } state_t;

  state_t st, nxt;
  logic [LCW-1:0] lock_cnt;
  logic [ZCW-1:0] zq_cnt;
  logic [SCW-1:0] stop_cnt;

  wire freq_ok   = req_period_ps <= PERIOD_W'(MAX_PERIOD_PS);
  wire freq_go   = freq_req && freq_ok;
  wire lock_done = lock_cnt >= LCW'(LOCK_CYCLES - 1);
  wire zq_done   = zq_cnt == ZCW'(ZQ_CYCLES);
  wire stop_done = stop_cnt >= SCW'(STOP_CYC - 1);
  wire halt      = !clk_stable || freq_go || sleep_req;

  assign clk_gate_en = (st == WAIT_CLK) || (st == ENABLE) || (st == LOCK_COUNT) || (st == READY);
  assign dll_run     = (st == ENABLE) || (st == LOCK_COUNT) || (st == READY) || (st == CLK_STOP);
  assign ready       = (st == READY) && pwr_good && !halt;

  always_comb begin
    nxt = st;
    if (!pwr_good) nxt = WAIT_POWER;
    else begin
      case (st)
        WAIT_POWER: nxt = WAIT_CLK;
        WAIT_CLK:   if (clk_stable) nxt = ENABLE;
        ENABLE:     nxt = halt ? CLK_STOP : LOCK_COUNT;
        LOCK_COUNT: if (halt) nxt = CLK_STOP;
                    else if (lock_done && zq_done) nxt = READY;
        READY:      if (halt) nxt = CLK_STOP;
        CLK_STOP:   if (stop_done && !halt) nxt = LOCK_COUNT;
        default:    nxt = WAIT_POWER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= WAIT_POWER;
      lock_cnt   <= '0;
      zq_cnt     <= '0;
      stop_cnt   <= '0;
      period_err <= 1'b0;
    end else begin
      st <= nxt;

      if (st != LOCK_COUNT)  lock_cnt <= '0;
      else if (!lock_done)   lock_cnt <= lock_cnt + 1'b1;

      if (st == WAIT_POWER)  zq_cnt <= '0;
      else if (zq_done)      zq_cnt <= zq_cnt;
      else if (rd_cmd)       zq_cnt <= '0;
      else if (clk_gate_en)  zq_cnt <= zq_cnt + 1'b1;

      if (st != CLK_STOP || freq_go) stop_cnt <= '0;
      else if (!stop_done)           stop_cnt <= stop_cnt + 1'b1;

      if (freq_req) period_err <= !freq_ok;
    end
  end
endmodule

module dll_bringup_seq_chk #(
  parameter int REF_PERIOD_PS = 5000,
  parameter int STOP_NS       = 30,
  parameter int LOCK_CYCLES   = 1024,
  parameter int MAX_PERIOD_PS = 8400,
  parameter int PERIOD_W      = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_good,
  input logic                clk_stable,
  input logic                freq_req,
  input logic [PERIOD_W-1:0] req_period_ps,
  input logic                sleep_req,
  input logic                dll_run,
  input logic                clk_gate_en,
  input logic                ready,
  input logic                period_err
);
  localparam int STOP_CYC = (STOP_NS * 1000 + REF_PERIOD_PS - 1) / REF_PERIOD_PS;

  int run_cnt;
  int off_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= 0;
      off_cnt <= 0;
    end else begin
      if (dll_run && clk_gate_en) run_cnt <= (run_cnt < LOCK_CYCLES + 4) ? run_cnt + 1 : run_cnt;
      else run_cnt <= 0;
      if (dll_run && !clk_gate_en) off_cnt <= (off_cnt < STOP_CYC + 4) ? off_cnt + 1 : off_cnt;
      else off_cnt <= 0;
    end
  end

  wire bad_req  = freq_req && (req_period_ps > PERIOD_W'(MAX_PERIOD_PS));
  wire good_req = freq_req && (req_period_ps <= PERIOD_W'(MAX_PERIOD_PS));

  AST_LOCK_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> run_cnt >= LOCK_CYCLES); // R3
  AST_STOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_gate_en) && dll_run) |-> off_cnt >= STOP_CYC); // R5
  AST_FREQ_GATES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (good_req && dll_run && pwr_good) |=> !clk_gate_en); // R5
  AST_BAD_PERIOD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> period_err); // R6
  AST_BAD_PERIOD_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && bad_req) |=> (dll_run && clk_gate_en)); // R6
  AST_SLEEP_GATES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && dll_run && pwr_good) |=> (dll_run && !clk_gate_en)); // R7
  AST_UNSTABLE_KEEPS_DLL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stable && dll_run && pwr_good) |=> (dll_run && !clk_gate_en)); // R8
  AST_PWR_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!dll_run && !clk_gate_en)); // R9
endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(
  .REF_PERIOD_PS(REF_PERIOD_PS), .STOP_NS(STOP_NS), .LOCK_CYCLES(LOCK_CYCLES),
  .MAX_PERIOD_PS(MAX_PERIOD_PS), .PERIOD_W(PERIOD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_stable(clk_stable),
  .freq_req(freq_req), .req_period_ps(req_period_ps), .sleep_req(sleep_req),
  .dll_run(dll_run), .clk_gate_en(clk_gate_en), .ready(ready), .period_err(period_err)
);

// File: tb/dll_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module dll_bringup_seq_tb_top;
  localparam int LOCK = 1024;
  localparam int ZQ   = 1024;
  localparam int STOP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 1'b0, clk_stable = 1'b0, freq_req = 1'b0, sleep_req = 1'b0, rd_cmd = 1'b0;
  logic [15:0] req_period_ps = 16'd5000;
  logic dll_run, clk_gate_en, ready, period_err;

  always #2.5 clk = ~clk;

  dll_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .freq_req(freq_req), .req_period_ps(req_period_ps), .sleep_req(sleep_req),
    .rd_cmd(rd_cmd), .dll_run(dll_run), .clk_gate_en(clk_gate_en),
    .ready(ready), .period_err(period_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  int low_run = 0, last_low_len = 0;
  bit prev_ready = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: compares each rise of ready with the queued expectation
  initial forever begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (ready && !prev_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected ready rise", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R3/R4 ready rise cycle", cyc, e);
        end
      end
      if (!clk_gate_en) low_run++;
      else begin
        if (low_run != 0) last_low_len = low_run;
        low_run = 0;
      end
      prev_ready = ready;
    end
  end

  initial begin
    #(100000 * 5);
    check(1'b0, "watchdog expired", cyc, -1);
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
    step(2);
    check(exp_q.size() == 0, "R3 expected rise consumed", exp_q.size(), 0);
  endtask

  task automatic freq_change(input int period);
    int m;
    m = cyc;
    req_period_ps = 16'(period);
    freq_req = 1'b1;
    #1;
    check(ready == 1'b0, "R5 ready drops with request", ready, 0);
    exp_q.push_back(m + 1 + STOP + LOCK);
    step(1);
    freq_req = 1'b0;
    check(period_err == 1'b0, "R6 accepted period clears flag", period_err, 0);
    wait_ready();
    check(last_low_len == STOP, "R5 clock stop length", last_low_len, STOP);
  endtask

  initial begin
    int p, n, s, u, a, r, lk, zq;
    step(3);
    rst_n = 1'b1;
    step(1);
    check(dll_run == 0, "R1 reset dll_run", dll_run, 0);
    check(clk_gate_en == 0, "R1 reset clk_gate_en", clk_gate_en, 0);
    check(ready == 0, "R1 reset ready", ready, 0);

    clk_stable = 1'b1;
    step(5);
    check(dll_run == 0, "R1 clk_stable ignored without power", dll_run, 0);
    check(clk_gate_en == 0, "R1 gate off without power", clk_gate_en, 0);

    clk_stable = 1'b0;
    pwr_good = 1'b1;
    p = cyc;
    step(1);
    check(clk_gate_en == 1, "R2 gate on after power good", clk_gate_en, 1);
    step(9);
    check(dll_run == 0, "R1 dll held off until clock stable", dll_run, 0);
    clk_stable = 1'b1;
    n = cyc;
    lk = n + 2 + LOCK;
    zq = p + 2 + ZQ;
    exp_q.push_back(lk > zq ? lk : zq);
    step(1);
    check(dll_run == 1, "R2 dll released after clock stable", dll_run, 1);
    wait_ready();

    // R5 boundary period then a nominal one
    freq_change(8400);

    // R6 refused period
    req_period_ps = 16'd9000;
    freq_req = 1'b1;
    #1;
    check(ready == 1'b1, "R6 bad period keeps ready", ready, 1);
    step(1);
    freq_req = 1'b0;
    check(period_err == 1'b1, "R6 period_err set", period_err, 1);
    step(4);
    check(ready == 1'b1 && clk_gate_en == 1'b1, "R6 no stop on bad period", ready, 1);
    freq_change(6000);

    // R7 low-power clock stop
    sleep_req = 1'b1;
    #1;
    check(ready == 0, "R7 ready drops on sleep", ready, 0);
    step(10);
    check(dll_run == 1 && clk_gate_en == 0, "R7 gate off, dll kept", clk_gate_en, 0);
    step(10);
    sleep_req = 1'b0;
    s = cyc;
    exp_q.push_back(s + 1 + LOCK);
    wait_ready();
    check(last_low_len == 20, "R7 stop follows sleep length", last_low_len, 20);

    // R8 long instability
    clk_stable = 1'b0;
    #1;
    check(ready == 0, "R8 ready drops on instability", ready, 0);
    step(10);
    check(dll_run == 1 && clk_gate_en == 0, "R8 dll stays enabled, gate off", dll_run, 1);
    clk_stable = 1'b1;
    u = cyc;
    exp_q.push_back(u + 1 + LOCK);
    wait_ready();

    // R8 short instability still stops for the full window
    u = cyc;
    clk_stable = 1'b0;
    step(2);
    clk_stable = 1'b1;
    exp_q.push_back(u + 1 + STOP + LOCK);
    wait_ready();
    check(last_low_len == STOP, "R8 minimum stop after short glitch", last_low_len, STOP);

    // R9 power loss, then R4 read restarts the impedance run
    pwr_good = 1'b0;
    #1;
    check(ready == 0, "R9 ready drops on power loss", ready, 0);
    step(1);
    check(dll_run == 0 && clk_gate_en == 0, "R9 dll and gate off", dll_run, 0);
    step(3);
    pwr_good = 1'b1;
    a = cyc;
    step(1000);
    rd_cmd = 1'b1;
    r = cyc;
    lk = a + 3 + LOCK;
    zq = r + 2 + ZQ;
    exp_q.push_back(lk > zq ? lk : zq);
    step(1);
    rd_cmd = 1'b0;
    step(LOCK - 990);
    check(ready == 0, "R4 ready held by impedance run", ready, 0);
    wait_ready();

    finish_run();
  end
endmodule